// File: doc/BRIEF.md
# Recursive Systematic Convolutional Encoder with Trellis Termination

This block is the constituent encoder of a turbo code. It takes one data bit per clock and runs it through an 8-state recursive shift register with three memory elements. It returns the data bit unchanged as the systematic output, along with a parity bit. A second parity bit can be enabled at build time for rate-1/5 operation. Interleaving, block storage and the multiplexing of the outputs belong to surrounding logic.

At the end of a block, the surrounding logic pulses a terminate command. For three clocks the encoder then uses its own feedback value as the input in place of data. This drives the register back to the all-zero state. The tail bits produced along the way appear on the systematic and parity outputs, and a tail flag marks them.

A clock enable freezes the whole block. A synchronous clear returns it to its idle, all-zero condition. All outputs are registered, one clock after the input that produced them.

Top module: `rsc_encoder`

## Requirements
- R1: On an enabled clock where `in_valid` is high and no termination is in progress or starting, the block outputs `sys_out` = `in_bit` on the next cycle, with `out_valid` high and `tail_out` low.
- R2: Let s1, s2, s3 be the register contents, newest first. The feedback is s2 xor s3, and the register input is a = input xor feedback (taps 1+D²+D³). `par0_out` = a xor s1 xor s3 (taps 1+D+D³). After that clock, the register holds a, s1, s2.
- R3: With `RATE_FIFTH` = 1, `par1_out` = a xor s1 xor s2 xor s3 (taps 1+D+D²+D³). With `RATE_FIFTH` = 0, `par1_out` stays 0.
- R4: An enabled clock with `term` high, when no termination is in progress, starts exactly three tail clocks, that clock included. On each tail clock the input is the feedback value, `sys_out` carries that value, the parity outputs carry the matching tail parity, and `out_valid` and `tail_out` are both high.
- R5: After the third tail clock the register is all zero. A following block therefore encodes exactly as it would after a clear.
- R6: `term` has priority over `in_valid` on the same clock, so that data bit is dropped. While a termination is in progress, both `in_valid` and `term` are ignored.
- R7: While `en` is low, the register, the termination progress and all outputs hold their values.
- R8: `rst` is synchronous, takes effect regardless of `en`, aborts any termination, zeroes the register and drives every output to 0.
- R9: An enabled clock with no valid data and no termination drives `out_valid` and `tail_out` low and leaves the register and the data outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear |
| en | input | 1 | Clock enable; low freezes the block |
| in_valid | input | 1 | `in_bit` carries a data bit |
| in_bit | input | 1 | Data bit to encode |
| term | input | 1 | Start the three-clock trellis termination |
| out_valid | output | 1 | Outputs carry a data or tail bit |
| sys_out | output | 1 | Systematic bit |
| par0_out | output | 1 | First parity bit |
| par1_out | output | 1 | Second parity bit (rate 1/5 only) |
| tail_out | output | 1 | Current output is a tail bit |

## Verification
The encoder is driven with several kinds of input:
- All-zero runs show that the register stays at zero.
- All-one runs and a single impulse expose each tap of the feedback and parity polynomials.
- Random data with gaps and freezes separates the hold behaviour of an idle clock from that of a frozen clock.

Terminations are requested at several points: immediately after data, together with a valid bit, again while a termination is already running, and cut short by a clear. Each case separates a correct tail from one that is late, too long, or that admits data. Every block that starts after a termination is compared against a fresh-start reference, which exposes any register left non-zero.

// File: rtl/rsc_encoder.sv
module rsc_encoder #(
  parameter bit RATE_FIFTH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic in_valid,
  input  logic in_bit,
  input  logic term,
  output logic out_valid,
  output logic sys_out,
  output logic par0_out,
  output logic par1_out,
  output logic tail_out
);

  localparam int MEM = 3;
  localparam int CW  = $clog2(MEM);

  logic [MEM-1:0] st;     // st[0] is the newest element
  logic [CW-1:0]  left;

  wire in_tail  = (left != '0);
  wire start    = term && !in_tail;
  wire tail_now = in_tail || start;
  wire fb       = st[1] ^ st[2];
  wire x        = tail_now ? fb : in_bit;
  wire a        = x ^ fb;
  wire p0       = a ^ st[0] ^ st[2];
  wire p1       = a ^ st[0] ^ st[1] ^ st[2];
  wire step     = tail_now || in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= '0;
      left      <= '0;
      out_valid <= 1'b0;
      sys_out   <= 1'b0;
      par0_out  <= 1'b0;
      par1_out  <= 1'b0;
      tail_out  <= 1'b0;
    end else if (en) begin
      if (step) begin
        st        <= {st[MEM-2:0], a};
        sys_out   <= x;
        par0_out  <= p0;
        par1_out  <= RATE_FIFTH ? p1 : 1'b0;
        out_valid <= 1'b1;
        tail_out  <= tail_now;
        left      <= start ? CW'(MEM-1) : (in_tail ? left - 1'b1 : '0);
      end else begin
        out_valid <= 1'b0;
        tail_out  <= 1'b0;
      end
    end
  end

  AST_TAIL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (en && left == CW'(1)) |=> (st == '0)); // R5

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(rst)) |=> $stable({st, left, out_valid, sys_out, par0_out, par1_out, tail_out})); // R7

  AST_TAIL_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    tail_out |-> out_valid); // R4

  AST_TERM_STARTS_TAIL: assert property (@(posedge clk) disable iff (rst)
    (en && term && left == '0) |=> (tail_out && out_valid)); // R4

  AST_NO_TAIL_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (en && left == CW'(1)) |=> !in_tail); // R6

  AST_CLEAR_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && !tail_out && st == '0)); // R8

endmodule

// File: tb/rsc_encoder_tb.sv
module rsc_encoder_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, in_valid = 1'b0, in_bit = 1'b0, term = 1'b0;
  logic ov, so, p0o, p1o, to;
  logic ov3, so3, p0o3, p1o3, to3;

  int checks = 0, errors = 0;

  // behavioural reference: history of register inputs, newest first
  bit hist[$] = '{0, 0, 0};
  int m_left = 0;
  bit e_v = 0, e_s = 0, e_p0 = 0, e_p1 = 0, e_t = 0;

  always #(PERIOD/2) clk = ~clk;

  rsc_encoder #(.RATE_FIFTH(1'b1)) u_dut (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_bit(in_bit), .term(term),
    .out_valid(ov), .sys_out(so), .par0_out(p0o), .par1_out(p1o), .tail_out(to));

  rsc_encoder #(.RATE_FIFTH(1'b0)) u_dut3 (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_bit(in_bit), .term(term),
    .out_valid(ov3), .sys_out(so3), .par0_out(p0o3), .par1_out(p1o3), .tail_out(to3));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit tailc, fb, x, a;
    if (rst) begin
      hist = '{0, 0, 0}; m_left = 0;
      e_v = 0; e_s = 0; e_p0 = 0; e_p1 = 0; e_t = 0;
    end else if (en) begin
      tailc = (m_left > 0) || term;
      if (tailc || in_valid) begin
        fb = hist[1] ^ hist[2];
        x = tailc ? fb : in_bit;
        a = x ^ fb;
        e_s = x;
        e_p0 = a ^ hist[0] ^ hist[2];
        e_p1 = a ^ hist[0] ^ hist[1] ^ hist[2];
        e_v = 1; e_t = tailc;
        hist.push_front(a);
        void'(hist.pop_back());
        if (m_left > 0) m_left--;
        else if (term) m_left = 2;
      end else begin
        e_v = 0; e_t = 0;
      end
    end
  endtask

  task automatic compare(input string req);
    chk(req, "out_valid", ov, e_v);
    chk(req, "tail_out", to, e_t);
    chk(req, "sys_out", so, e_s);
    chk(req, "par0_out", p0o, e_p0);
    chk("R3", "par1_out", p1o, e_p1);
    chk("R3", "par1_out rate-1/3", p1o3, 1'b0);
    chk(req, "par0_out rate-1/3", p0o3, e_p0);
  endtask

  task automatic cyc(input string req, input bit r, input bit e, input bit v, input bit b, input bit t);
    @(negedge clk);
    rst = r; en = e; in_valid = v; in_bit = b; term = t;
    @(posedge clk);
    model_step();
    #1 compare(req);
  endtask

  task automatic terminate(input string req);
    cyc(req, 0, 1, 0, 0, 1);
    cyc(req, 0, 1, 0, 0, 0);
    cyc(req, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc("R8", 1, 0, 0, 0, 0);
    cyc("R8", 1, 1, 0, 0, 0);
    // zeros keep register at zero
    for (int i = 0; i < 6; i++) cyc("R2", 0, 1, 1, 0, 0);
    // impulse response
    cyc("R1", 0, 1, 1, 1, 0);
    for (int i = 0; i < 10; i++) cyc("R2", 0, 1, 1, 0, 0);
    terminate("R4");
    // all ones
    for (int i = 0; i < 9; i++) cyc("R2", 0, 1, 1, 1, 0);
    terminate("R4");
    // next block after tail must match fresh start
    cyc("R5", 0, 1, 1, 1, 0);
    for (int i = 0; i < 5; i++) cyc("R5", 0, 1, 1, 0, 0);
    // term together with valid data: data dropped
    cyc("R6", 0, 1, 1, 1, 1);
    cyc("R6", 0, 1, 1, 0, 1);
    cyc("R6", 0, 1, 1, 1, 1);
    cyc("R5", 0, 1, 1, 1, 0);
    // freeze mid-block and mid-tail
    cyc("R1", 0, 1, 1, 1, 0);
    cyc("R7", 0, 0, 1, 0, 0);
    cyc("R7", 0, 0, 0, 1, 1);
    cyc("R1", 0, 1, 1, 0, 0);
    cyc("R4", 0, 1, 0, 0, 1);
    cyc("R7", 0, 0, 1, 1, 1);
    cyc("R4", 0, 1, 0, 0, 0);
    cyc("R9", 0, 1, 0, 1, 0);
    cyc("R4", 0, 1, 0, 0, 0);
    cyc("R9", 0, 1, 0, 1, 0);
    // clear in the middle of a tail
    cyc("R1", 0, 1, 1, 1, 0);
    cyc("R1", 0, 1, 1, 1, 0);
    cyc("R4", 0, 1, 0, 0, 1);
    cyc("R8", 1, 0, 1, 1, 0);
    cyc("R8", 0, 1, 1, 1, 0);
    cyc("R8", 0, 1, 1, 0, 0);
    // random blocks with gaps, freezes and terminations
    for (int blk = 0; blk < 40; blk++) begin
      int n = 5 + ($urandom % 30);
      for (int i = 0; i < n; i++) begin
        bit e = ($urandom % 8) != 0;
        bit v = ($urandom % 4) != 0;
        cyc(e ? (v ? "R2" : "R9") : "R7", 0, e, v, 1'($urandom), 0);
      end
      if (($urandom % 3) == 0) cyc("R6", 0, 1, 1, 1'($urandom), 1);
      else cyc("R4", 0, 1, 0, 0, 1);
      for (int i = 0; i < 3; i++)
        cyc("R6", 0, ($urandom % 5) != 0, 1'($urandom), 1'($urandom), 1'($urandom));
      for (int i = 0; i < 4; i++) cyc("R5", 0, 1, 1, 1'($urandom), 0);
      cyc("R4", 0, 1, 0, 0, 1);
      cyc("R4", 0, 1, 0, 0, 0);
      cyc("R4", 0, 1, 0, 0, 0);
      cyc("R9", 0, 1, 0, 0, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule